// File: doc/BRIEF.md
# Double-Buffered SPI Master

A byte-wide SPI master that a host controls through eight small registers. The host writes a byte into a transmit holding register and the block moves it into an output shift register, generates eight serial clock periods and, on the same clock, shifts a byte in from the slave into a receive holding register. The host can place the next byte in the holding register while the current byte shifts, so a stream runs with no idle time between bytes. Slave select is left to a general-purpose pin under software control.

Serial clock polarity, sampling phase and bit order are chosen while a hold bit keeps the engine idle. The serial clock period comes from a divisor split over a low and a high byte register. Receive and transmit-ready events raise flags that can each be masked. An encoded vector register reports the most urgent unmasked event, and reading it clears the event it reported.

Top module: `spi_dbuf_master`

## Requirements
- R1: Once the hold bit is clear, a host write to the transmit register (address 3) starts one 8-bit frame with no other command; a frame produces exactly 16 serial clock transitions.
- R2: The serial clock period is D input clock cycles, where D is the 16-bit divisor {address 2, address 1}; D below 2 acts as 2. The first half of each bit lasts floor(D/2) cycles and the second half the rest, so a run of F gapless frames spans F*8*D - floor(D/2) cycles from its first to its last serial clock transition.
- R3: Control register (address 0) bit 1 sets the serial clock idle level (1 means high); bit 2 selects capture on the first (0) or second (1) transition of each bit, with MOSI changing on the other transition. The serial clock is back at its idle level after every frame.
- R4: Control register bit 3 selects bit order: 0 sends and receives the most significant bit first, 1 the least significant bit first.
- R5: At the last capture transition of a frame the received byte is written to the receive register (address 4) and the receive flag (status bit 0) is set; a read of address 4 clears the flag.
- R6: If a byte completes while the receive flag is still set, the new byte replaces the old one and the overrun bit (status bit 2) is set; a read of address 4 clears overrun.
- R7: The transmit-ready flag (status bit 1) clears on a transmit write and sets again when the held byte moves into the shift register; a byte held at the end of a frame starts the next frame with no gap, otherwise the busy bit (status bit 3) falls and the serial clock idles.
- R8: The vector register (address 7) reads 2 when a receive event is pending, 4 when only a transmit-ready event is pending, 0 otherwise; reading it clears the event it reported.
- R9: Enable register (address 6) bit 0 unmasks receive and bit 1 unmasks transmit-ready; a masked event never appears in the vector, and the irq output is high exactly when an unmasked event is pending.
- R10: Control bit 0 (hold, 1 after reset) keeps the engine idle, aborts a frame in progress, empties the transmit register, sets transmit-ready, clears receive and overrun, and ignores transmit writes. After reset the control register reads 0x01, the divisor low byte 0x02 and status 0x02.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (triggers read side effects) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| irq | output | 1 | Any unmasked event pending |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |

## Verification
A wrong count or phase in the clock engine shows within one frame as a serial clock span that differs from the divisor formula or as a captured byte that disagrees at the slave model. A lost or doubled handover between the holding and shift registers shows as a gap in the serial clock span of a streamed pair, a wrong byte order at the slave, or a transmit-ready flag that does not return. Flag and vector errors appear at the next status or vector read after the frame, so every event is followed by a read that exposes it.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
   localparam int FRAME_BITS = 8;
   localparam int EDGES      = 2 * FRAME_BITS;

   typedef enum logic [2:0] {
      A_CTRL   = 3'd0,
      A_DIVLO  = 3'd1,
      A_DIVHI  = 3'd2,
      A_TXBUF  = 3'd3,
      A_RXBUF  = 3'd4,
      A_STATUS = 3'd5,
      A_IEN    = 3'd6,
      A_VEC    = 3'd7
   } reg_addr_e;

   localparam logic [7:0] VEC_NONE = 8'd0;
   localparam logic [7:0] VEC_RX   = 8'd2;
   localparam logic [7:0] VEC_TX   = 8'd4;

   typedef struct packed {
      logic lsb_first;
      logic cpha;
      logic cpol;
      logic hold;
   } ctrl_t;
endpackage

// File: rtl/spi_dbuf_engine.sv
module spi_dbuf_engine
   import spi_dbuf_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             cpol,
   input  logic             cpha,
   input  logic             lsb_first,
   input  logic [DIV_W-1:0] div,
   input  logic             tx_full,
   input  logic [7:0]       tx_data,
   input  logic             miso,
   output logic             take_o,
   output logic             rx_done_o,
   output logic [7:0]       rx_byte_o,
   output logic             busy_o,
   output logic             sclk_o,
   output logic             mosi_o
);
   localparam int EW = $clog2(EDGES);

   logic             busy_q, lvl_q;
   logic [EW-1:0]    idx_q;
   logic [DIV_W-1:0] cnt_q;
   logic [7:0]       tx_q, rx_q;

   logic [DIV_W-1:0] neff, h1, h2;
   logic             edge_now, last_edge, sample_edge, last_sample, shift_edge;
   logic [7:0]       rx_next;

   always_comb begin
      neff        = (div < DIV_W'(2)) ? DIV_W'(2) : div;
      h1          = neff >> 1;
      h2          = neff - h1;
      edge_now    = busy_q && (cnt_q == '0);
      last_edge   = (idx_q == EW'(EDGES - 1));
      sample_edge = cpha ? idx_q[0] : !idx_q[0];
      last_sample = cpha ? last_edge : (idx_q == EW'(EDGES - 2));
      shift_edge  = cpha ? (!idx_q[0] && (idx_q != '0)) : (idx_q[0] && !last_edge);
      rx_next     = lsb_first ? {miso, rx_q[7:1]} : {rx_q[6:0], miso};
   end

   assign take_o    = !hold && tx_full && (!busy_q || (edge_now && last_edge));
   assign rx_done_o = !hold && edge_now && sample_edge && last_sample;
   assign rx_byte_o = rx_next;
   assign busy_o    = busy_q;
   assign sclk_o    = cpol ^ lvl_q;
   assign mosi_o    = lsb_first ? tx_q[0] : tx_q[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         lvl_q  <= 1'b0;
         idx_q  <= '0;
         cnt_q  <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
      end else if (hold) begin
         busy_q <= 1'b0;
         lvl_q  <= 1'b0;
         idx_q  <= '0;
         cnt_q  <= '0;
      end else if (take_o) begin
         busy_q <= 1'b1;
         lvl_q  <= 1'b0;
         idx_q  <= '0;
         cnt_q  <= h1 - DIV_W'(1);
         tx_q   <= tx_data;
      end else if (edge_now) begin
         lvl_q <= ~lvl_q;
         if (sample_edge) rx_q <= rx_next;
         if (shift_edge)  tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
         if (last_edge) begin
            busy_q <= 1'b0;
         end else begin
            idx_q <= idx_q + EW'(1);
            cnt_q <= idx_q[0] ? (h1 - DIV_W'(1)) : (h2 - DIV_W'(1));
         end
      end else if (busy_q) begin
         cnt_q <= cnt_q - DIV_W'(1);
      end
   end

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !busy_q);
   assert_gapless_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_now && last_edge && tx_full && !hold) |=> (busy_q && idx_q == '0));
   assert_idle_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_now && last_edge && !tx_full) |=> !busy_q);
   assert_level_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0 && !hold) |=> $stable(lvl_q));
endmodule

// File: rtl/spi_dbuf_regs.sv
module spi_dbuf_regs
   import spi_dbuf_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [2:0]       addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output ctrl_t            ctrl_o,
   output logic [DIV_W-1:0] div_o,
   output logic             tx_full_o,
   output logic [7:0]       tx_data_o,
   input  logic             take,
   input  logic             rx_done,
   input  logic [7:0]       rx_byte,
   input  logic             busy,
   output logic             irq_o
);
   ctrl_t      ctrl_q;
   logic [7:0] divlo_q, divhi_q, txbuf_q, rxbuf_q;
   logic       txfull_q, txflag_q, rxflag_q, ovr_q;
   logic [1:0] ien_q;

   logic       wr_tx, rd_rx, rd_vec, rx_pend, tx_pend, clr_rx, clr_tx;
   logic [7:0] vec;

   always_comb begin
      wr_tx   = wr_en && (addr == A_TXBUF) && !ctrl_q.hold;
      rd_rx   = rd_en && (addr == A_RXBUF);
      rd_vec  = rd_en && (addr == A_VEC);
      rx_pend = rxflag_q && ien_q[0];
      tx_pend = txflag_q && ien_q[1];
      vec     = rx_pend ? VEC_RX : (tx_pend ? VEC_TX : VEC_NONE);
      clr_rx  = rd_rx || (rd_vec && rx_pend);
      clr_tx  = rd_vec && !rx_pend && tx_pend;
   end

   always_comb begin
      case (addr)
         A_CTRL:   rdata = {4'b0, ctrl_q};
         A_DIVLO:  rdata = divlo_q;
         A_DIVHI:  rdata = divhi_q;
         A_RXBUF:  rdata = rxbuf_q;
         A_STATUS: rdata = {4'b0, busy, ovr_q, txflag_q, rxflag_q};
         A_IEN:    rdata = {6'b0, ien_q};
         A_VEC:    rdata = vec;
         default:  rdata = 8'h00;
      endcase
   end

   assign ctrl_o    = ctrl_q;
   assign div_o     = {divhi_q[DIV_W-9:0], divlo_q};
   assign tx_full_o = txfull_q;
   assign tx_data_o = txbuf_q;
   assign irq_o     = rx_pend || tx_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= ctrl_t'(4'b0001);
         divlo_q  <= 8'h02;
         divhi_q  <= 8'h00;
         txbuf_q  <= 8'h00;
         rxbuf_q  <= 8'h00;
         ien_q    <= 2'b00;
         txfull_q <= 1'b0;
         txflag_q <= 1'b1;
         rxflag_q <= 1'b0;
         ovr_q    <= 1'b0;
      end else begin
         if (wr_en) begin
            case (addr)
               A_CTRL:  ctrl_q  <= ctrl_t'(wdata[3:0]);
               A_DIVLO: divlo_q <= wdata;
               A_DIVHI: divhi_q <= wdata;
               A_IEN:   ien_q   <= wdata[1:0];
               default: ;
            endcase
         end
         if (wr_tx) txbuf_q <= wdata;
         if (ctrl_q.hold) begin
            txfull_q <= 1'b0;
            txflag_q <= 1'b1;
            rxflag_q <= 1'b0;
            ovr_q    <= 1'b0;
         end else begin
            if (wr_tx)     txfull_q <= 1'b1;
            else if (take) txfull_q <= 1'b0;
            if (wr_tx)       txflag_q <= 1'b0;
            else if (take)   txflag_q <= 1'b1;
            else if (clr_tx) txflag_q <= 1'b0;
            if (rx_done) begin
               rxbuf_q  <= rx_byte;
               rxflag_q <= 1'b1;
               if (rxflag_q && !clr_rx) ovr_q <= 1'b1;
               else if (rd_rx)          ovr_q <= 1'b0;
            end else begin
               if (clr_rx) rxflag_q <= 1'b0;
               if (rd_rx)  ovr_q    <= 1'b0;
            end
         end
      end
   end

   assert_rx_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> rxflag_q);
   assert_overrun_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(rx_done && rxflag_q));
   assert_vec_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vec && rx_pend && !rx_done && !ctrl_q.hold) |=> !rxflag_q);
   assert_tx_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr_tx) |=> txflag_q);
   assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == 2'b00) |-> !irq_o);
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
   import spi_dbuf_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_wr,
   input  logic       host_rd,
   input  logic [2:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic       irq,
   output logic       sclk,
   output logic       mosi,
   input  logic       miso
);
   generate
      if (DIV_W < 9 || DIV_W > 16) begin : g_bad_div
         initial $error("DIV_W must lie between 9 and 16");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [DIV_W-1:0] div;
   logic             tx_full, take, rx_done, busy;
   logic [7:0]       tx_data, rx_byte;

   spi_dbuf_regs #(.DIV_W(DIV_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_wr),
      .rd_en    (host_rd),
      .addr     (host_addr),
      .wdata    (host_wdata),
      .rdata    (host_rdata),
      .ctrl_o   (ctrl),
      .div_o    (div),
      .tx_full_o(tx_full),
      .tx_data_o(tx_data),
      .take     (take),
      .rx_done  (rx_done),
      .rx_byte  (rx_byte),
      .busy     (busy),
      .irq_o    (irq)
   );

   spi_dbuf_engine #(.DIV_W(DIV_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (ctrl.hold),
      .cpol      (ctrl.cpol),
      .cpha      (ctrl.cpha),
      .lsb_first (ctrl.lsb_first),
      .div       (div),
      .tx_full   (tx_full),
      .tx_data   (tx_data),
      .miso      (miso),
      .take_o    (take),
      .rx_done_o (rx_done),
      .rx_byte_o (rx_byte),
      .busy_o    (busy),
      .sclk_o    (sclk),
      .mosi_o    (mosi)
   );
endmodule

// File: tb/sim_spi_dbuf_master.sv
module sim_spi_dbuf_master;
   localparam logic [2:0] RCTRL = 3'd0, RDLO = 3'd1, RDHI = 3'd2, RTX = 3'd3,
                          RRX = 3'd4, RST = 3'd5, RIEN = 3'd6, RVEC = 3'd7;

   logic       clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0, miso = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq, sclk, mosi;

   always #5 clk = ~clk;

   spi_dbuf_master u0 (
      .clk(clk), .rst_n(rst_n), .host_wr(wr), .host_rd(rd), .host_addr(addr),
      .host_wdata(wdata), .host_rdata(rdata), .irq(irq), .sclk(sclk),
      .mosi(mosi), .miso(miso)
   );

   int checks = 0, errors = 0, cyc = 0;
   logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsb = 0;
   logic prev_sclk = 0, prev_mosi = 0;
   int edge_cnt = 0, first_t = 0, last_t = 0, slv_j = 0, slv_k = 0, cap_n = 0;
   logic [7:0] slv_sh = 0;
   logic [7:0] slv_tx [0:63];
   logic [7:0] cap [0:63];

   // slave model: captures MOSI and drives MISO at the selected capture transitions
   always @(negedge clk) begin
      cyc++;
      if (sclk !== prev_sclk) begin
         edge_cnt++;
         if (edge_cnt == 1) first_t = cyc;
         last_t = cyc;
         if ((prev_sclk == cfg_cpol) ^ cfg_cpha) begin
            slv_sh = cfg_lsb ? {prev_mosi, slv_sh[7:1]} : {slv_sh[6:0], prev_mosi};
            slv_j++;
            if (slv_j == 8) begin
               if (cap_n < 64) cap[cap_n] = slv_sh;
               cap_n++;
               slv_j = 0;
               if (slv_k < 63) slv_k++;
            end
         end
      end
      prev_sclk = sclk;
      prev_mosi = mosi;
      miso = cfg_lsb ? slv_tx[slv_k][slv_j] : slv_tx[slv_k][7-slv_j];
   end

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic mon_clear();
      #2;
      edge_cnt = 0; slv_j = 0; slv_k = 0; cap_n = 0; slv_sh = 0;
      miso = cfg_lsb ? slv_tx[0][0] : slv_tx[0][7];
   endtask

   task automatic setup(input logic pol, input logic pha, input logic lsb, input logic [7:0] d);
      cfg_cpol = pol; cfg_cpha = pha; cfg_lsb = lsb;
      wr_reg(RCTRL, {4'b0, lsb, pha, pol, 1'b1});
      wr_reg(RDLO, d);
      wr_reg(RDHI, 8'h00);
      wr_reg(RCTRL, {4'b0, lsb, pha, pol, 1'b0});
      mon_clear();
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 3000; i++) begin
         rd_reg(RST, s);
         if (!s[3]) return;
      end
      chk("wait_idle busy stuck", 1, 0);
   endtask

   function automatic int span_exp(input int d, input int frames);
      int n;
      n = (d < 2) ? 2 : d;
      return frames * 8 * n - n / 2;
   endfunction

   logic [7:0] v, b0, b1;
   logic [7:0] stream [0:5];
   int         divs [0:7] = '{2, 4, 6, 3, 0, 1, 5, 8};

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed1234));
      for (int i = 0; i < 64; i++) slv_tx[i] = 8'($urandom);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // reset state (R10)
      rd_reg(RCTRL, v); chk("R10 ctrl after reset", v, 8'h01);
      rd_reg(RDLO, v);  chk("R10 divisor low after reset", v, 8'h02);
      rd_reg(RST, v);   chk("R10 status after reset", v, 8'h02);
      rd_reg(RVEC, v);  chk("R8 vector idle", v, 8'h00);
      chk("R3 sclk idle after reset", sclk, 0);
      chk("R9 irq after reset", irq, 0);

      // transmit write while held is ignored (R10)
      mon_clear();
      wr_reg(RTX, 8'hA5);
      repeat (30) @(negedge clk);
      chk("R10 no frame while held", edge_cnt, 0);
      wr_reg(RCTRL, 8'h00);
      repeat (40) @(negedge clk);
      chk("R10 held write discarded", edge_cnt, 0);
      rd_reg(RST, v); chk("R10 status after release", v, 8'h02);

      // all modes, assorted divisors (R1..R5)
      for (int m = 0; m < 8; m++) begin
         logic [7:0] tx;
         tx = 8'($urandom);
         setup(m[0], m[1], m[2], 8'(divs[m]));
         wr_reg(RTX, tx);
         wait_idle();
         chk($sformatf("R1 edge count mode %0d", m), edge_cnt, 16);
         chk($sformatf("R2 clock span mode %0d div %0d", m, divs[m]),
             last_t - first_t, span_exp(divs[m], 1));
         chk($sformatf("R3 R4 slave capture mode %0d", m), cap[0], tx);
         chk($sformatf("R3 sclk idle mode %0d", m), sclk, m[0]);
         rd_reg(RST, v); chk($sformatf("R5 status after frame mode %0d", m), v, 8'h03);
         rd_reg(RRX, v); chk($sformatf("R5 received byte mode %0d", m), v, slv_tx[0]);
         rd_reg(RST, v); chk($sformatf("R5 flag cleared mode %0d", m), v, 8'h02);
      end

      // double buffering and overrun (R6, R7)
      setup(1'b0, 1'b0, 1'b0, 8'd2);
      b0 = 8'h3C; b1 = 8'hC3;
      wr_reg(RTX, b0);
      repeat (2) @(negedge clk);
      rd_reg(RST, v); chk("R7 ready after handover", v, 8'h0A);
      wr_reg(RTX, b1);
      rd_reg(RST, v); chk("R7 ready cleared by write", v, 8'h08);
      wait_idle();
      chk("R7 two frames edges", edge_cnt, 32);
      chk("R7 gapless span", last_t - first_t, span_exp(2, 2));
      chk("R7 first byte order", cap[0], b0);
      chk("R7 second byte order", cap[1], b1);
      rd_reg(RST, v); chk("R6 overrun status", v, 8'h07);
      rd_reg(RRX, v); chk("R6 newest byte kept", v, slv_tx[1]);
      rd_reg(RST, v); chk("R6 overrun cleared", v, 8'h02);

      // masking and vector (R8, R9)
      wr_reg(RTX, 8'h11); wait_idle();
      rd_reg(RVEC, v); chk("R9 vector with all masked", v, 8'h00);
      chk("R9 irq masked", irq, 0);
      wr_reg(RIEN, 8'h02);
      #1 chk("R9 irq tx unmasked", irq, 1);
      rd_reg(RVEC, v); chk("R9 rx masked shows tx", v, 8'h04);
      rd_reg(RVEC, v); chk("R8 tx cleared by vector read", v, 8'h00);
      rd_reg(RST, v);  chk("R9 rx flag kept while masked", v, 8'h01);
      wr_reg(RIEN, 8'h03);
      rd_reg(RVEC, v); chk("R8 rx reported", v, 8'h02);
      rd_reg(RVEC, v); chk("R8 nothing left", v, 8'h00);
      wr_reg(RTX, 8'h22); wait_idle();
      rd_reg(RVEC, v); chk("R8 rx has priority", v, 8'h02);
      rd_reg(RVEC, v); chk("R8 tx after rx", v, 8'h04);
      rd_reg(RVEC, v); chk("R8 empty after both", v, 8'h00);
      #1 chk("R9 irq low after clears", irq, 0);
      wr_reg(RIEN, 8'h00);

      // random streamed bytes fed on transmit-ready (R7)
      setup(1'($urandom), 1'($urandom), 1'($urandom), 8'd2);
      for (int i = 0; i < 6; i++) begin
         stream[i] = 8'($urandom);
         do rd_reg(RST, v); while (!v[1]);
         wr_reg(RTX, stream[i]);
      end
      wait_idle();
      chk("R7 stream edges", edge_cnt, 96);
      chk("R7 stream gapless", last_t - first_t, span_exp(2, 6));
      for (int i = 0; i < 6; i++)
         chk($sformatf("R7 stream byte %0d", i), cap[i], stream[i]);
      rd_reg(RRX, v); chk("R5 stream last byte", v, slv_tx[5]);

      // hold during a frame aborts it (R10)
      setup(1'b1, 1'b0, 1'b0, 8'd4);
      wr_reg(RTX, 8'h5A);
      repeat (10) @(negedge clk);
      wr_reg(RCTRL, 8'h03);
      repeat (3) @(negedge clk);
      rd_reg(RST, v); chk("R10 hold aborts frame", v, 8'h02);
      chk("R10 sclk idle after abort", sclk, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule